// File: doc/BRIEF.md
# Integrating Converter Sequencer

This block controls an external integrator and comparator that together form a dual-slope analog-to-digital converter. On a start request it first shorts the integrator for a fixed settling interval. It then connects the integrator to the analog input for a fixed run-up period. After that it switches the integrator to the negative reference and counts clocks until the comparator reports that the integrator has discharged to zero. The count at that point is the conversion result. A larger input charges the integrator higher, so the discharge takes longer and the count is larger.

The comparator arrives asynchronously and passes through a synchronizer before the sequencer uses it. If the discharge runs past the full count range without a zero report, the block flags an overrange and saturates the result. Each conversion ends with a one-cycle completion pulse. The result word then holds until the next conversion completes.

Top module: `dual_slope_ctrl`

## Requirements
- R1: After reset, all three switch controls, `busy_o`, `done_o`, `overrange_o` and `result_o` are 0.
- R2: A `start_i` sampled high while idle (neither busy nor done) closes only the short switch from the next cycle, for exactly AZ_CLKS cycles.
- R3: The input switch is then closed for exactly RUNUP_CLKS cycles. The reference switch closes in the cycle right after the input switch opens.
- R4: The comparator passes through SYNC_STAGES (default 2) flip-flops. The result equals the number of reference-phase cycles that elapse before the cycle in which the synchronized comparator is first seen high. With the default setting, a comparator that rises during reference cycle j gives result j+2.
- R5: If no zero report arrives within 2^RES_W reference-phase cycles, `overrange_o` is set to 1 and `result_o` is set to all ones. A report seen in the last of those cycles gives the all-ones result with `overrange_o` at 0.
- R6: `done_o` pulses high for exactly one cycle, in the cycle after the last reference-phase cycle. In that same cycle `busy_o` and all switches are 0.
- R7: `result_o` and `overrange_o` change only in a cycle where `done_o` is high.
- R8: `start_i` has no effect while a conversion is in progress or during the done cycle.
- R9: At most one switch control is high in any cycle. `busy_o` is high in every short, input and reference cycle and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request |
| cmp_zero_i | input | 1 | Asynchronous comparator: integrator has reached zero |
| sw_short_o | output | 1 | Close the integrator short (auto-zero) switch |
| sw_input_o | output | 1 | Connect the integrator to the analog input |
| sw_ref_o | output | 1 | Connect the integrator to the negative reference |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| overrange_o | output | 1 | Last conversion timed out |
| result_o | output | RES_W | Discharge count of the last conversion |

## Verification
The bench raises the comparator at chosen reference-phase cycles and predicts each result from the synchronizer latency. An off-by-one in the count or in the sync depth would show as a result shifted by one or two. The two cycles around the range limit are exercised: a report just in time must give all ones with no flag, and one cycle later must give the overrange. A design that compared the counter against the wrong terminal value would swap these two outcomes. The bench also pulses start in the middle of run-up and checks that the phase lengths are unchanged. It then runs a normal conversion after an overrange to catch a flag that never clears.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_AZ    = 3'd1,
      ST_INT   = 3'd2,
      ST_DEINT = 3'd3,
      ST_DONE  = 3'd4
   } dsc_state_e;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsc_timer.sv
module dsc_timer #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_o <= '0;
      else if (clr_i) cnt_o <= '0;
      else            cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/dsc_seq_fsm.sv
module dsc_seq_fsm
   import dsc_pkg::*;
#(
   parameter int RES_W      = 8,
   parameter int AZ_CLKS    = 16,
   parameter int RUNUP_CLKS = 256,
   parameter int CNT_W      = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             zero_seen_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             cnt_clr_o,
   output dsc_state_e       state_o,
   output logic [RES_W-1:0] result_o,
   output logic             ovr_o
);
   localparam logic [CNT_W-1:0] AZ_LAST    = CNT_W'(AZ_CLKS - 1);
   localparam logic [CNT_W-1:0] RUNUP_LAST = CNT_W'(RUNUP_CLKS - 1);
   localparam logic [CNT_W-1:0] DEINT_LAST = CNT_W'((2 ** RES_W) - 1);

   dsc_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start_i) state_d = ST_AZ;
         ST_AZ:    if (cnt_i == AZ_LAST) state_d = ST_INT;
         ST_INT:   if (cnt_i == RUNUP_LAST) state_d = ST_DEINT;
         ST_DEINT: if (zero_seen_i || cnt_i == DEINT_LAST) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   assign cnt_clr_o = (state_d != state_q) || (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o <= '0;
         ovr_o    <= 1'b0;
      end else if (state_q == ST_DEINT) begin
         if (zero_seen_i) begin
            result_o <= cnt_i[RES_W-1:0];
            ovr_o    <= 1'b0;
         end else if (cnt_i == DEINT_LAST) begin
            result_o <= '1;
            ovr_o    <= 1'b1;
         end
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
   import dsc_pkg::*;
#(
   parameter int RES_W       = 8,
   parameter int AZ_CLKS     = 16,
   parameter int RUNUP_CLKS  = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cmp_zero_i,
   output logic             sw_short_o,
   output logic             sw_input_o,
   output logic             sw_ref_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             overrange_o,
   output logic [RES_W-1:0] result_o
);
   localparam int SPAN_MAX = (RUNUP_CLKS > AZ_CLKS) ?
                             ((RUNUP_CLKS > (2 ** RES_W)) ? RUNUP_CLKS : (2 ** RES_W)) :
                             ((AZ_CLKS > (2 ** RES_W)) ? AZ_CLKS : (2 ** RES_W));
   localparam int CNT_W = $clog2(SPAN_MAX) + 1;

   generate
      if (RES_W < 2 || RES_W > 20) begin : g_bad_res
         $error("RES_W out of range");
      end
      if (AZ_CLKS < 1 || RUNUP_CLKS < 1) begin : g_bad_len
         $error("phase lengths must be positive");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             zero_seen;
   logic             cnt_clr;
   logic [CNT_W-1:0] cnt;
   dsc_state_e       state;

   dsc_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmp_zero_i),
      .q_o   (zero_seen)
   );

   dsc_timer #(.CNT_W(CNT_W)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr),
      .cnt_o (cnt)
   );

   dsc_seq_fsm #(
      .RES_W      (RES_W),
      .AZ_CLKS    (AZ_CLKS),
      .RUNUP_CLKS (RUNUP_CLKS),
      .CNT_W      (CNT_W)
   ) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .zero_seen_i (zero_seen),
      .cnt_i       (cnt),
      .cnt_clr_o   (cnt_clr),
      .state_o     (state),
      .result_o    (result_o),
      .ovr_o       (overrange_o)
   );

   always_comb begin
      sw_short_o = (state == ST_AZ);
      sw_input_o = (state == ST_INT);
      sw_ref_o   = (state == ST_DEINT);
      busy_o     = (state == ST_AZ) || (state == ST_INT) || (state == ST_DEINT);
      done_o     = (state == ST_DONE);
   end
endmodule

// File: rtl/dsc_ctrl_chk.sv
module dsc_ctrl_chk #(
   parameter int RES_W      = 8,
   parameter int AZ_CLKS    = 16,
   parameter int RUNUP_CLKS = 256
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             sw_short_o,
   input logic             sw_input_o,
   input logic             sw_ref_o,
   input logic             busy_o,
   input logic             done_o,
   input logic             overrange_o,
   input logic [RES_W-1:0] result_o
);
   int unsigned az_n, run_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         az_n  <= 0;
         run_n <= 0;
      end else begin
         az_n  <= sw_short_o ? az_n + 1 : 0;
         run_n <= sw_input_o ? run_n + 1 : 0;
      end
   end

   p_start_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !done_o) |=> sw_short_o);
   p_short_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_short_o) |-> (az_n == AZ_CLKS));
   p_runup_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_input_o) |-> (run_n == RUNUP_CLKS && sw_ref_o));
   p_ovr_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      overrange_o |-> (result_o == {RES_W{1'b1}}));
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(overrange_o)));
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && sw_input_o) |=> (sw_input_o || sw_ref_o));
   p_one_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sw_short_o, sw_input_o, sw_ref_o}));
   p_busy_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o == (sw_short_o || sw_input_o || sw_ref_o));
endmodule

bind dual_slope_ctrl dsc_ctrl_chk #(
   .RES_W      (RES_W),
   .AZ_CLKS    (AZ_CLKS),
   .RUNUP_CLKS (RUNUP_CLKS)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .sw_short_o  (sw_short_o),
   .sw_input_o  (sw_input_o),
   .sw_ref_o    (sw_ref_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .overrange_o (overrange_o),
   .result_o    (result_o)
);

// File: tb/dual_slope_ctrl_tb_top.sv
module dual_slope_ctrl_tb_top;
   localparam int RES_W      = 8;
   localparam int AZ_CLKS    = 16;
   localparam int RUNUP_CLKS = 256;
   localparam int MAXV       = (2 ** RES_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic cmp_zero_i = 1'b0;
   logic sw_short_o, sw_input_o, sw_ref_o, busy_o, done_o, overrange_o;
   logic [RES_W-1:0] result_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   typedef struct packed {
      logic [RES_W-1:0] res;
      logic             ovr;
   } exp_t;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   dual_slope_ctrl #(
      .RES_W(RES_W), .AZ_CLKS(AZ_CLKS), .RUNUP_CLKS(RUNUP_CLKS), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_zero_i(cmp_zero_i),
      .sw_short_o(sw_short_o), .sw_input_o(sw_input_o), .sw_ref_o(sw_ref_o),
      .busy_o(busy_o), .done_o(done_o), .overrange_o(overrange_o),
      .result_o(result_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   // monitor: scoreboard plus hold and pulse checks
   logic [RES_W-1:0] last_res = '0;
   logic             last_ovr = 1'b0;
   logic [RES_W-1:0] prev_res = '0;
   logic             prev_ovr = 1'b0;
   bit               multi_sw = 1'b0;
   bit               busy_bad = 1'b0;
   bit               chk_after = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if ((sw_short_o + sw_input_o + sw_ref_o) > 1) multi_sw = 1'b1;
         if (busy_o != (sw_short_o | sw_input_o | sw_ref_o)) busy_bad = 1'b1;
         if (chk_after) begin
            check(!done_o, "R6 done single cycle", done_o, 0);
            chk_after = 1'b0;
         end
         if (done_o) begin
            exp_t e;
            check(prev_res == last_res && prev_ovr == last_ovr, "R7 result held",
                  prev_res, last_res);
            check(!busy_o && !sw_short_o && !sw_input_o && !sw_ref_o,
                  "R6 idle outputs at done", busy_o, 0);
            check(!multi_sw, "R9 one switch", multi_sw, 0);
            check(!busy_bad, "R9 busy matches phases", busy_bad, 0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R4 unexpected done", 1, 0);
            end else begin
               e = exp_q.pop_front();
               check(result_o == e.res, "R4/R5 result", result_o, e.res);
               check(overrange_o == e.ovr, "R5 overrange flag", overrange_o, e.ovr);
            end
            last_res = result_o;
            last_ovr = overrange_o;
            chk_after = 1'b1;
         end
         prev_res = result_o;
         prev_ovr = overrange_o;
      end
   end

   // driver: d < 0 means the comparator never reports zero
   task automatic run_conv(input int d, input bit poke_start);
      exp_t e;
      int n;
      if (d >= 0 && d + 2 <= MAXV) begin
         e.res = RES_W'(d + 2); e.ovr = 1'b0;
      end else begin
         e.res = '1; e.ovr = 1'b1;
      end
      exp_q.push_back(e);
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      n = 0;
      while (sw_short_o && !sw_input_o) begin n++; @(negedge clk); end
      check(n == AZ_CLKS, "R2 short phase length", n, AZ_CLKS);
      n = 0;
      while (sw_input_o) begin
         n++;
         if (poke_start && n == 10) start_i = 1'b1;
         else start_i = 1'b0;
         @(negedge clk);
      end
      start_i = 1'b0;
      check(n == RUNUP_CLKS, "R3 run-up length", n, RUNUP_CLKS);
      check(sw_ref_o, "R3 reference follows input", sw_ref_o, 1);
      if (d >= 0) begin
         for (int k = 0; k < d && busy_o; k++) @(negedge clk);
         cmp_zero_i = 1'b1;
      end
      while (busy_o) @(negedge clk);
      @(negedge clk);
      cmp_zero_i = 1'b0;
      if (poke_start) check(!busy_o && !sw_short_o, "R8 start ignored while busy", busy_o, 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!sw_short_o && !sw_input_o && !sw_ref_o, "R1 switches off", sw_short_o, 0);
      check(!busy_o && !done_o, "R1 busy/done low", busy_o, 0);
      check(result_o == 0 && !overrange_o, "R1 result clear", result_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_conv(0, 1'b0);
      run_conv(40, 1'b0);
      run_conv(MAXV - 2, 1'b0);   // R5 last-cycle report: all ones, no flag
      run_conv(MAXV - 1, 1'b0);   // R5 one cycle late: overrange
      run_conv(7, 1'b0);          // flag must clear
      run_conv(-1, 1'b0);         // R5 no report at all
      run_conv(20, 1'b1);         // R8 start during run-up
      run_conv(100, 1'b0);
      check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      wait (cyc > 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule